// File: doc/BRIEF.md
# Display-List Frame Word Interpreter

This block walks through a display list held in frame memory and carries out each 16-bit word it reads. An internal frame counter supplies the read address. The interpreter takes one word every eight pixel-clock cycles, which is one slot. At the last cycle of a slot it decodes the word's upper byte. The word can load eight monochrome pixels for serial output, raise or drop horizontal sync, raise or drop vertical sync, set or clear the frame-restart flag, load the sound register, or do nothing.

Software defines all video timing. Sync position, sync polarity and frame length come only from where command words are placed in memory. The counter wraps back to address 0 only when a restart command tells it to. A fetch-enable input marks slots in which the memory is busy elsewhere. In such a slot the word is neither decoded nor advanced past.

Top module: `display_list_engine`

## Requirements
- R1: While `rst` is high, and in the cycle after it is released, `fetch_addr` is 0, `hsync`, `vsync`, `pix_out` and all of `ctrl_flags` are 0, and `sound` is 0.
- R2: A slot lasts 8 clock cycles. The first slot starts at the first rising edge after reset is released, and the word is decoded at the edge that ends the slot. If the restart flag is clear after that decode, `fetch_addr` advances by one at that same edge.
- R3: A word whose upper byte is 0x80 sends its low byte out on `pix_out` over the 8 cycles that follow the decode edge. The most significant bit comes first and one bit is shown per cycle.
- R4: `pix_out` stays 0 for the whole slot that follows a decode of any other word, and for the whole slot that follows a stalled slot.
- R5: Upper byte 0x81 sets `hsync` and 0x82 clears it. The level holds until the next such command. `ctrl_flags[0]` mirrors `hsync`.
- R6: Upper byte 0x83 sets `vsync` and 0x84 clears it. The level holds until the next such command. `ctrl_flags[1]` mirrors `vsync`.
- R7: Upper byte 0x85 sets the restart flag `ctrl_flags[2]`. The counter goes to address 0 at that decode edge and stays there while the flag is set. Upper byte 0x86 clears the flag, and the next address is then one past the current one.
- R8: Upper byte 0x87 copies the low byte into `sound`, which keeps that value until the next such word.
- R9: Upper byte 0xFF and every upper byte not listed above leave the sync levels, the restart flag and `sound` unchanged. The address still advances.
- R10: If `fetch_en` is low at a slot's decode edge, that word has no effect and `fetch_addr` does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous reset, active high |
| fetch_en | input | 1 | High when the frame memory is read for the current slot |
| frame_word | input | 16 | Word read from frame memory at `fetch_addr` |
| fetch_addr | output | ADDR_W | Frame counter, used as the read address |
| pix_out | output | 1 | Serial monochrome pixel |
| hsync | output | 1 | Horizontal sync level |
| vsync | output | 1 | Vertical sync level |
| ctrl_flags | output | 3 | Flag vector: bit 0 hsync, bit 1 vsync, bit 2 restart |
| sound | output | 8 | Sound register value |

## Verification
The hardest condition to reach is the restart loop. A restart command must send the counter to address 0 in the very slot that decodes it. The counter must then stay parked there while the word at 0 is anything other than the clear command, and leave only when that word changes. The directed part of the stimulus sets this up by placing a restart word at the end of a short program. It then rewrites the word at address 0 between slots: first to a no-op, to hold the counter at 0, and then to the clear command, to release it. The random part adds rare restart words and frequent stalled slots on top of this.

// File: rtl/dle_pkg.sv
package dle_pkg;

    localparam int WORD_W   = 16;
    localparam int ARG_W    = 8;
    localparam int OPC_W    = WORD_W - ARG_W;
    localparam int SLOT_LEN = ARG_W;   // one pixel per clock, one byte per slot

    typedef enum logic [OPC_W-1:0] {
        OPC_PIXELS   = 8'h80,
        OPC_HS_SET   = 8'h81,
        OPC_HS_CLR   = 8'h82,
        OPC_VS_SET   = 8'h83,
        OPC_VS_CLR   = 8'h84,
        OPC_RST_SET  = 8'h85,
        OPC_RST_CLR  = 8'h86,
        OPC_SOUND    = 8'h87,
        OPC_IDLE     = 8'hFF
    } opcode_e;

    typedef struct packed {
        logic frame_rst;
        logic vsync;
        logic hsync;
    } flags_t;

    typedef struct packed {
        logic             pix_load;
        logic             hs_set;
        logic             hs_clr;
        logic             vs_set;
        logic             vs_clr;
        logic             rst_set;
        logic             rst_clr;
        logic             snd_load;
        logic [ARG_W-1:0] arg;
    } cmd_t;

    function automatic cmd_t decode_word(input logic [WORD_W-1:0] w);
        cmd_t c;
        c     = '0;
        c.arg = w[ARG_W-1:0];
        case (w[WORD_W-1:ARG_W])
            OPC_PIXELS:  c.pix_load = 1'b1;
            OPC_HS_SET:  c.hs_set   = 1'b1;
            OPC_HS_CLR:  c.hs_clr   = 1'b1;
            OPC_VS_SET:  c.vs_set   = 1'b1;
            OPC_VS_CLR:  c.vs_clr   = 1'b1;
            OPC_RST_SET: c.rst_set  = 1'b1;
            OPC_RST_CLR: c.rst_clr  = 1'b1;
            OPC_SOUND:   c.snd_load = 1'b1;
            default:     ;
        endcase
        return c;
    endfunction

    function automatic flags_t next_flags(input flags_t f, input cmd_t c);
        flags_t n;
        n = f;
        if (c.hs_set)  n.hsync     = 1'b1;
        if (c.hs_clr)  n.hsync     = 1'b0;
        if (c.vs_set)  n.vsync     = 1'b1;
        if (c.vs_clr)  n.vsync     = 1'b0;
        if (c.rst_set) n.frame_rst = 1'b1;
        if (c.rst_clr) n.frame_rst = 1'b0;
        return n;
    endfunction

endpackage

// File: rtl/dle_slot_timer.sv
module dle_slot_timer #(
    parameter int SLOT_LEN = 8
) (
    input  logic clk,
    input  logic rst,
    output logic slot_end
);
    localparam int PH_W = (SLOT_LEN > 1) ? $clog2(SLOT_LEN) : 1;
    localparam logic [PH_W-1:0] LAST = PH_W'(SLOT_LEN - 1);

    logic [PH_W-1:0] phase;

    always_ff @(posedge clk) begin
        if (rst)                phase <= '0;
        else if (phase == LAST) phase <= '0;
        else                    phase <= phase + 1'b1;
    end

    assign slot_end = (phase == LAST);
endmodule

// File: rtl/dle_frame_counter.sv
module dle_frame_counter #(
    parameter int ADDR_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              advance,
    input  logic              to_zero,
    output logic [ADDR_W-1:0] addr
);
    always_ff @(posedge clk) begin
        if (rst)          addr <= '0;
        else if (advance) addr <= to_zero ? '0 : addr + 1'b1;
    end
endmodule

// File: rtl/dle_pixel_shifter.sv
module dle_pixel_shifter #(
    parameter int PIX_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             slot_end,
    input  logic             load,
    input  logic [PIX_W-1:0] data,
    output logic             pix
);
    logic [PIX_W-1:0] sr;

    always_ff @(posedge clk) begin
        if (rst)           sr <= '0;
        else if (slot_end) sr <= load ? data : '0;
        else               sr <= {sr[PIX_W-2:0], 1'b0};
    end

    assign pix = sr[PIX_W-1];
endmodule

// File: rtl/display_list_engine.sv
module display_list_engine
    import dle_pkg::*;
#(
    parameter int ADDR_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              fetch_en,
    input  logic [15:0]       frame_word,
    output logic [ADDR_W-1:0] fetch_addr,
    output logic              pix_out,
    output logic              hsync,
    output logic              vsync,
    output logic [2:0]        ctrl_flags,
    output logic [7:0]        sound
);
    logic   slot_end;
    logic   take;
    cmd_t   cmd;
    flags_t flags_q;
    flags_t flags_d;

    dle_slot_timer #(.SLOT_LEN(SLOT_LEN)) u_timer (
        .clk      (clk),
        .rst      (rst),
        .slot_end (slot_end)
    );

    always_comb begin
        cmd     = decode_word(frame_word);
        take    = slot_end && fetch_en;
        flags_d = take ? next_flags(flags_q, cmd) : flags_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            flags_q <= '0;
            sound   <= '0;
        end else begin
            flags_q <= flags_d;
            if (take && cmd.snd_load) sound <= cmd.arg;
        end
    end

    dle_frame_counter #(.ADDR_W(ADDR_W)) u_counter (
        .clk     (clk),
        .rst     (rst),
        .advance (take),
        .to_zero (flags_d.frame_rst),
        .addr    (fetch_addr)
    );

    dle_pixel_shifter #(.PIX_W(ARG_W)) u_shifter (
        .clk      (clk),
        .rst      (rst),
        .slot_end (slot_end),
        .load     (take && cmd.pix_load),
        .data     (cmd.arg),
        .pix      (pix_out)
    );

    assign hsync      = flags_q.hsync;
    assign vsync      = flags_q.vsync;
    assign ctrl_flags = flags_q;
endmodule

// File: rtl/dle_checker.sv
module dle_checker
    import dle_pkg::*;
#(
    parameter int ADDR_W = 16
) (
    input logic              clk,
    input logic              rst,
    input logic              fetch_en,
    input logic [15:0]       frame_word,
    input logic [ADDR_W-1:0] fetch_addr,
    input logic              pix_out,
    input logic              hsync,
    input logic              vsync,
    input logic [2:0]        ctrl_flags,
    input logic [7:0]        sound,
    input logic              slot_end
);
    // R2
    slot_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        slot_end |=> !slot_end);

    // R10
    addr_move_chk: assert property (@(posedge clk) disable iff (rst)
        !$stable(fetch_addr) |-> $past(slot_end && fetch_en));

    // R7
    restart_park_chk: assert property (@(posedge clk) disable iff (rst)
        ctrl_flags[2] |-> (fetch_addr == '0));

    // R5
    hsync_move_chk: assert property (@(posedge clk) disable iff (rst)
        !$stable(hsync) |-> $past(slot_end && fetch_en));

    // R8
    sound_move_chk: assert property (@(posedge clk) disable iff (rst)
        !$stable(sound) |-> $past(slot_end && fetch_en && frame_word[15:8] == 8'h87));

    // R4
    dark_slot_chk: assert property (@(posedge clk) disable iff (rst)
        $past(slot_end && !(fetch_en && frame_word[15:8] == 8'h80)) |-> !pix_out);
endmodule

bind display_list_engine dle_checker #(.ADDR_W(ADDR_W)) chk (.*);

// File: tb/display_list_engine_test.sv
module display_list_engine_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        fetch_en = 1'b0;
    logic [15:0] frame_word;
    logic [15:0] fetch_addr;
    logic        pix_out, hsync, vsync;
    logic [2:0]  ctrl_flags;
    logic [7:0]  sound;

    logic [15:0] mem [256];
    int checks = 0;
    int errors = 0;

    logic [15:0] m_addr;
    logic        m_hs, m_vs, m_rst;
    logic [7:0]  m_snd, m_pix;

    always #2.5 clk = ~clk;

    assign frame_word = mem[fetch_addr[7:0]];

    display_list_engine uut (
        .clk(clk), .rst(rst), .fetch_en(fetch_en), .frame_word(frame_word),
        .fetch_addr(fetch_addr), .pix_out(pix_out), .hsync(hsync),
        .vsync(vsync), .ctrl_flags(ctrl_flags), .sound(sound)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic logic [15:0] rand_word();
        int r;
        r = $urandom % 12;
        case (r)
            0, 1, 2, 3: return {8'h80, 8'($urandom)};
            4:  return 16'h8100;
            5:  return 16'h8200;
            6:  return 16'h8300;
            7:  return 16'h8400;
            8:  return {8'h87, 8'($urandom)};
            9:  return (($urandom % 8) == 0) ? 16'h8500 : 16'hFF00;
            10: return 16'h8600;
            default: return 16'($urandom);
        endcase
    endfunction

    // expected effect of one slot, from the requirement list
    task automatic model_step(input logic en);
        logic [15:0] w;
        w = mem[m_addr[7:0]];
        m_pix = 8'h00;
        if (en) begin
            case (w[15:8])
                8'h80: m_pix = w[7:0];
                8'h81: m_hs = 1'b1;
                8'h82: m_hs = 1'b0;
                8'h83: m_vs = 1'b1;
                8'h84: m_vs = 1'b0;
                8'h85: m_rst = 1'b1;
                8'h86: m_rst = 1'b0;
                8'h87: m_snd = w[7:0];
                default: ;
            endcase
            m_addr = m_rst ? 16'h0000 : m_addr + 16'h0001;
        end
    endtask

    // called at a negedge just after a slot boundary
    task automatic run_slot(input logic en);
        fetch_en = en;
        chk("R2 address", fetch_addr, m_addr);
        chk("R5 hsync", {hsync, ctrl_flags[0]}, {m_hs, m_hs});
        chk("R6 vsync", {vsync, ctrl_flags[1]}, {m_vs, m_vs});
        chk("R7 restart flag", ctrl_flags[2], m_rst);
        chk("R8 sound", sound, m_snd);
        for (int k = 0; k < 8; k++) begin
            if (k > 0) @(negedge clk);
            if (m_pix != 8'h00) chk("R3 pixel", pix_out, m_pix[7-k]);
            else                chk("R4 dark pixel", pix_out, 1'b0);
        end
        model_step(en);
        @(negedge clk);
    endtask

    initial begin
        void'($urandom(32'd4021));
        for (int i = 0; i < 256; i++) mem[i] = 16'hFF00;
        mem[0]  = 16'h8600;
        mem[1]  = 16'h8100;
        mem[2]  = 16'h80A5;
        mem[3]  = 16'h873C;
        mem[4]  = 16'h8081;
        mem[5]  = 16'h1234;
        mem[6]  = 16'h8300;
        mem[7]  = 16'h8200;
        mem[8]  = 16'h8400;
        mem[9]  = 16'h80C3;
        mem[10] = 16'h8500;
        m_addr = 0; m_hs = 0; m_vs = 0; m_rst = 0; m_snd = 0; m_pix = 0;

        repeat (4) @(posedge clk);
        @(negedge clk);
        // R1: reset state
        chk("R1 address", fetch_addr, 16'h0000);
        chk("R1 flags", {hsync, vsync, ctrl_flags, pix_out}, 6'b0);
        chk("R1 sound", sound, 8'h00);
        rst = 1'b0;
        chk("R1 after release", {fetch_addr, sound, ctrl_flags, pix_out}, 28'h0);

        for (int s = 0; s < 5; s++) run_slot(1'b1);
        // R9: unknown opcode at address 5 changes nothing but the address
        run_slot(1'b1);
        chk("R9 unknown opcode", {hsync, vsync, ctrl_flags[2], sound}, {1'b1, 1'b0, 1'b0, 8'h3C});
        chk("R9 address advanced", fetch_addr, 16'd6);
        for (int s = 0; s < 3; s++) run_slot(1'b1);
        // R10: stalled slot at address 9
        run_slot(1'b0);
        chk("R10 address held", fetch_addr, 16'd9);
        run_slot(1'b1);
        run_slot(1'b1);
        // R7: restart word sent the counter to 0
        chk("R7 restart to zero", fetch_addr, 16'd0);
        mem[0] = 16'hFF00;
        run_slot(1'b1);
        run_slot(1'b1);
        chk("R7 parked at zero", {fetch_addr, ctrl_flags[2]}, {16'd0, 1'b1});
        mem[0] = 16'h8600;
        run_slot(1'b1);
        chk("R7 released", {fetch_addr, ctrl_flags[2]}, {16'd1, 1'b0});

        // constrained random display lists
        for (int i = 1; i < 256; i++) mem[i] = rand_word();
        for (int s = 0; s < 1500; s++) run_slot(($urandom % 5) != 0);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual timeout expected completion");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule